// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Generator

This block turns a byte-addressed partial-word store into a single word-aligned write request for a big-endian bus of `LANES` byte lanes (four by default, 32 bits). The caller presents a byte address, a store value and a mode bit. In begin mode the write covers the addressed byte through the last byte of the word. In end mode it covers the first byte of the word up to, but not including, the addressed byte. The byte enables and the write data are worked out together, so each enabled lane carries the source byte that belongs to it.

The upstream side and the downstream side each use a valid/ready handshake. One output register sits between them. A request is accepted when that register is empty or is draining in the same cycle. In end mode with a zero offset no lane is enabled. The request is still issued, and a flag marks it, so that the memory system still runs its permission check and its dirty-line marking for that word.

Top module: `pwstore_lane_gen`

## Requirements
- R1: In begin mode (`req_mode`=0) with byte offset k (the low two address bits), `wr_be[i]` is 1 exactly for lanes i >= k. Lane i is `wr_be[i]`, and lane 0 is the most significant byte `wr_data[31:24]`.
- R2: In end mode (`req_mode`=1) with byte offset k, `wr_be[i]` is 1 exactly for lanes i < k.
- R3: In end mode with offset 0, a request is still issued with `wr_be`=0 and `wr_probe`=1. In every other case `wr_probe`=0.
- R4: Each enabled lane of `wr_data` holds the byte of `req_data` that has the same lane position. In begin mode this places the low bytes of the value in the trailing lanes, and in end mode it places the high bytes in the leading lanes. Disabled lanes are zero.
- R5: `wr_addr` equals `req_addr` with its two low bits cleared.
- R6: A begin-mode store at offset 1 goes out as exactly one request with three lanes enabled. At offset 0 it goes out as one request with all lanes enabled.
- R7: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr`, `wr_be`, `wr_data` and `wr_probe` hold their values.
- R8: Reset clears `wr_valid`, and `req_ready` is 1 after reset.
- R9: `req_ready` = !`wr_valid` || `wr_ready`. A request accepted at a clock edge appears on the outputs right after that edge, and back-to-back requests pass at one per cycle when `wr_ready`=1.
- R10: The number of enabled lanes is LANES-k in begin mode and k in end mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 8*LANES | Store value |
| req_mode | input | 1 | 0 = begin mode, 1 = end mode |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Downstream takes the write |
| wr_addr | output | ADDR_W | Word-aligned address |
| wr_be | output | LANES | Byte enables, bit i = lane i (lane 0 most significant) |
| wr_data | output | 8*LANES | Lane-aligned write data, unselected lanes zero |
| wr_probe | output | 1 | Zero-byte access kept only for the permission check |

## Verification
The assertions assume that the downstream side holds no expectation on `wr_data` beyond the enabled lanes, and that the upstream side drives `req_mode` and `req_addr` to known values whenever `req_valid` is high. The hold check also assumes that `wr_ready` is the only thing that can release the output register. The stimulus never leaves inputs unknown while valid. It drops `req_valid` between single requests, or keeps it high only while `wr_ready` is high for the back-to-back run. It also holds `wr_ready` low for a chosen number of cycles so that the stall path is exercised on purpose.

// File: rtl/pwstore_pkg.sv
package pwstore_pkg;

  typedef enum logic {
    MODE_BEGIN = 1'b0,
    MODE_END   = 1'b1
  } pw_mode_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/pw_lane_decode.sv
module pw_lane_decode
  import pwstore_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic             mode,
  input  logic [OFF_W-1:0] offset,
  output logic [LANES-1:0] be,
  output logic             zero_access
);

  // lane i selected in begin mode when at or past the offset,
  // in end mode when strictly before it
  function automatic logic lane_sel(input logic m, input logic [OFF_W-1:0] lane,
                                    input logic [OFF_W-1:0] off);
    if (m == MODE_END) return lane < off;
    else               return lane >= off;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = lane_sel(mode, OFF_W'(i), offset);
  end

  assign zero_access = (mode == MODE_END) && (offset == '0);

endmodule

// File: rtl/pw_lane_merge.sv
module pw_lane_merge
  import pwstore_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW = LANES * BYTE_W
) (
  input  logic [DW-1:0]    value,
  input  logic [LANES-1:0] be,
  output logic [DW-1:0]    lanes
);

  // big-endian: lane i sits at the byte counted from the top of the word
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned LO = (LANES - 1 - i) * BYTE_W;
    assign lanes[LO +: BYTE_W] = be[i] ? value[LO +: BYTE_W] : '0;
  end

endmodule

// File: rtl/pw_req_reg.sv
module pw_req_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_bits,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_bits
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (load)           out_bits  <= in_bits;
    end
  end

endmodule

// File: rtl/pwstore_lane_gen.sv
module pwstore_lane_gen
  import pwstore_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned PW    = ADDR_W + LANES + DW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic              req_mode,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_be,
  output logic [DW-1:0]     wr_data,
  output logic              wr_probe
);

  logic [OFF_W-1:0]  offset;
  logic [LANES-1:0]  dec_be;
  logic              dec_zero;
  logic [DW-1:0]     dec_data;
  logic [ADDR_W-1:0] dec_addr;
  logic [PW-1:0]     pay_in, pay_out;
  logic              accept;

  assign offset   = req_addr[OFF_W-1:0];
  assign dec_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  pw_lane_decode #(.LANES(LANES)) u_dec (
    .mode(req_mode), .offset(offset), .be(dec_be), .zero_access(dec_zero)
  );

  pw_lane_merge #(.LANES(LANES)) u_merge (
    .value(req_data), .be(dec_be), .lanes(dec_data)
  );

  assign pay_in = {dec_addr, dec_be, dec_data, dec_zero};

  pw_req_reg #(.W(PW)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_bits(pay_in),
    .out_valid(wr_valid), .out_ready(wr_ready), .out_bits(pay_out)
  );

  assign {wr_addr, wr_be, wr_data, wr_probe} = pay_out;
  assign accept = req_valid && req_ready;

  function automatic logic [DW-1:0] be_to_bits(input logic [LANES-1:0] b);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[(LANES-1-i)*BYTE_W +: BYTE_W] = {BYTE_W{b[i]}};
    return r;
  endfunction

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_be)
                              && $stable(wr_data) && $stable(wr_probe));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wr_valid);

  p_probe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_probe == (wr_be == '0)));

  p_lanes_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data & ~be_to_bits(wr_be)) == '0));

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[OFF_W-1:0] == '0));

  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($countones(dec_be) ==
                (req_mode ? int'(offset) : int'(LANES) - int'(offset))));

endmodule

// File: tb/sim_pwstore_lane_gen.sv
`timescale 1ns/1ps
module sim_pwstore_lane_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_mode = 1'b0, wr_ready = 1'b0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic        req_ready, wr_valid, wr_probe;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pwstore_lane_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .wr_probe(wr_probe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic m, input int k);
    return m ? 4'((1 << k) - 1) : 4'(~((1 << k) - 1));
  endfunction

  function automatic logic [31:0] exp_data(input logic m, input int k, input logic [31:0] v);
    logic [63:0] low = (64'd1 << (8 * (4 - k))) - 64'd1;
    return m ? (v & ~low[31:0]) : (v & low[31:0]);
  endfunction

  task automatic check_out(input logic m, input logic [31:0] a, input logic [31:0] v);
    int k = int'(a[1:0]);
    chk("R9 valid", 64'(wr_valid), 64'd1);
    chk(m ? "R2 be" : "R1 be", 64'(wr_be), 64'(exp_be(m, k)));
    chk("R4 data", 64'(wr_data), 64'(exp_data(m, k, v)));
    chk("R5 addr", 64'(wr_addr), 64'({a[31:2], 2'b00}));
    chk("R3 probe", 64'(wr_probe), 64'(m && k == 0));
    chk("R10 count", 64'($countones(wr_be)), 64'(m ? k : 4 - k));
  endtask

  task automatic send(input logic m, input logic [31:0] a, input logic [31:0] v, input int stall);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_addr = a; req_data = v; wr_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(m, a, v);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R9 ready low", 64'(req_ready), 64'd0);
      check_out(m, a, v);   // R7 held
    end
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    chk("R9 drained", 64'(wr_valid), 64'd0);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hA1B2C3D4; pats[1] = 32'hFFFFFFFF;
    pats[2] = 32'h01020304; pats[3] = 32'h80000001;
    repeat (3) @(negedge clk);
    chk("R8 valid", 64'(wr_valid), 64'd0);
    chk("R8 ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 4; p++)
          send(m[0], 32'h1000_0040 + 32'(p * 256) + 32'(k), pats[p], p % 3);
    // R6: begin offset 1 is one request with three lanes, then nothing follows
    send(1'b0, 32'h0000_0101, 32'h11223344, 0);
    @(negedge clk);
    chk("R6 single", 64'(wr_valid), 64'd0);
    // back-to-back with ready high (R9)
    @(negedge clk);
    wr_ready = 1'b1;
    req_valid = 1'b1; req_mode = 1'b1; req_addr = 32'h2000_0003; req_data = 32'hDEADBEEF;
    @(negedge clk);
    check_out(1'b1, 32'h2000_0003, 32'hDEADBEEF);
    chk("R9 ready b2b", 64'(req_ready), 64'd1);
    req_mode = 1'b0; req_addr = 32'h2000_0002; req_data = 32'hCAFEF00D;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(1'b0, 32'h2000_0002, 32'hCAFEF00D);
    @(negedge clk);
    chk("R9 empty", 64'(wr_valid), 64'd0);
    // reset mid-stall clears output (R8)
    wr_ready = 1'b0;
    req_valid = 1'b1; req_mode = 1'b0; req_addr = 32'h4; req_data = 32'h5;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 async clear", 64'(wr_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule